// File: doc/BRIEF.md
# Direct-Control Device Responder

This block is the device end of a 16-bit minicomputer I/O channel. The channel starts a direct-control sequence by raising an outbound tag and pulsing a strobe while it presents a 16-bit command address. The block compares the device-address byte of that address with its own address, a parameter, and decodes the direction and the function. On a write it checks odd parity on each data byte and stores the word in one of a small set of device registers. On a read it returns a register, a single byte or its status, and generates odd parity for each byte. When the channel services an interrupt, the block returns an identification word made of an information byte and its own address.

A parameter selects a byte-oriented variant. In that variant the high data byte is never checked, never stored and never used. A write that fails its parity check is dropped and raises a sticky error flag. A status read reports the flag, and a control write clears it. Each accepted sequence is answered by a one-cycle acknowledge. The data bus is driven, with its output enable raised, only in the acknowledge cycle of a read or of an interrupt service.

Bit numbering follows the channel convention: bus bit 0 is the most significant. Bus bit n is therefore port index 15-n, and data bits 0-7 (the high byte) are `data_in[15:8]`.

Top module: `dcr_responder`

## Requirements
- R1: After reset, `ack` and `data_oe` are 0, `data_out` and `par_out` are 0, and a status read returns 0.
- R2: A sequence is taken only when `dc_tag` and `strobe` are both high and `addr_in[7:0]` equals `DEV_ADDR`. The channel-select bit `addr_in[15]` has no effect on this. Any other strobe produces no `ack` and leaves `data_oe` low.
- R3: `ack` is high for exactly the one cycle after the strobe cycle of an accepted sequence, and it is low in the following idle cycle.
- R4: `addr_in[14]` = 1 means write and 0 means read. `addr_in[13:12]` is the function: 00 word, 01 byte, 10 control/status, 11 reserved. `addr_in[11:8]` selects register 0..`NREG`-1. A write to an index at or above `NREG` changes nothing, and a read from such an index returns 0. A reserved-function read returns 0, and a reserved-function write has no effect.
- R5: Parity is odd per byte: `par_in[1]` covers `data_in[15:8]` and `par_in[0]` covers `data_in[7:0]`. A write whose checked byte has bad parity is discarded and sets the error flag. The flag then stays set, even across later good writes.
- R6: With `BYTE_MODE`=1, only the low byte is parity-checked, and a word write stores `{8'h00, data_in[7:0]}`. With `BYTE_MODE`=0, both bytes are checked and a word write stores all 16 bits.
- R7: A byte write stores `{8'h00, data_in[7:0]}` in both modes.
- R8: A word read returns the selected register, and a byte read returns `{8'h00, reg[7:0]}`. In both cases `data_oe` is 1 in the `ack` cycle.
- R9: Whenever `data_oe` is 1, `par_out[1]` and `par_out[0]` give odd parity over `data_out[15:8]` and `data_out[7:0]`.
- R10: A status read returns the error flag in `data_out[0]`, with the other bits 0. A control write with good parity clears the flag.
- R11: A cycle with `intr_svc` high is answered in the next cycle with `ack`=1, `data_oe`=1 and `data_out` = `{intr_info, DEV_ADDR}`, whatever the address and tag. A direct-control strobe in the same cycle is ignored and changes no state.
- R12: Whenever `data_oe` is 0, `data_out` and `par_out` are all 0. This includes the `ack` cycle of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dc_tag | input | 1 | Outbound direct-control tag |
| strobe | input | 1 | One-cycle sequence strobe from the channel |
| addr_in | input | 16 | Command address: channel select, direction, function, register index, device address |
| data_in | input | 16 | Write data word |
| par_in | input | 2 | Odd parity bits for the write data bytes |
| intr_svc | input | 1 | Interrupt-service request for this device |
| intr_info | input | 8 | Interrupt information byte |
| ack | output | 1 | One-cycle acknowledge of an accepted sequence |
| data_oe | output | 1 | Data bus drive enable |
| data_out | output | 16 | Read or interrupt word |
| par_out | output | 2 | Odd parity of the driven bytes |

## Verification
The assertions assume that every input is synchronous to `clk` and that `data_in`, `par_in` and `intr_info` matter only in the cycle their strobe is high. The interrupt-word property compares against the information byte of the previous cycle. The stimulus changes inputs only on the falling edge, holds each strobe for one cycle and follows every sequence with an idle cycle, so each acknowledge stands alone. Corrupted parity is applied on purpose to one byte at a time, and the stimulus runs in parallel through a word-oriented and a byte-oriented instance.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int BUS_W = 16;
  localparam int NBYTE = BUS_W / 8;

  typedef enum logic [1:0] {
    FN_WORD = 2'b00,
    FN_BYTE = 2'b01,
    FN_CTRL = 2'b10,
    FN_RSVD = 2'b11
  } fn_e;

  typedef struct packed {
    logic       sel;
    logic       wr;
    fn_e        fn;
    logic [3:0] idx;
  } cmd_t;

  function automatic logic odd_bit(input logic [7:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
  import dcr_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'h5A
) (
  input  logic             tag,
  input  logic             strobe,
  input  logic [BUS_W-1:0] addr,
  output cmd_t             cmd
);
  logic unused_chan_sel;
  assign unused_chan_sel = addr[15];

  always_comb begin
    cmd.sel = tag & strobe & (addr[7:0] == DEV_ADDR);
    cmd.wr  = addr[14];
    cmd.fn  = fn_e'(addr[13:12]);
    cmd.idx = addr[11:8];
  end
endmodule

// File: rtl/dcr_parity_chk.sv
module dcr_parity_chk #(
  parameter int NB = 2
) (
  input  logic [NB*8-1:0] data,
  input  logic [NB-1:0]   par,
  input  logic [NB-1:0]   mask,
  output logic            err
);
  logic [NB-1:0] bad;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign bad[i] = mask[i] & ~(^{data[i*8 +: 8], par[i]});
  end

  assign err = |bad;
endmodule

// File: rtl/dcr_store.sv
module dcr_store #(
  parameter int NREG = 4,
  parameter int W    = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [3:0]   wr_idx,
  input  logic [W-1:0] wr_data,
  input  logic         set_err,
  input  logic         clr_err,
  input  logic [3:0]   rd_idx,
  output logic [W-1:0] rd_data,
  output logic         err_flag
);
  localparam int IDX_W = $clog2(NREG);

  logic [W-1:0] regs_q [NREG];
  logic [W-1:0] regs_d [NREG];
  logic         err_q, err_d;
  logic         wr_ok, rd_ok;

  assign wr_ok = 32'(wr_idx) < NREG;
  assign rd_ok = 32'(rd_idx) < NREG;

  always_comb begin
    for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
    if (wr_en && wr_ok) regs_d[wr_idx[IDX_W-1:0]] = wr_data;
  end

  always_comb begin
    err_d = err_q;
    if (set_err)      err_d = 1'b1;
    else if (clr_err) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      err_q <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
      err_q <= err_d;
    end
  end

  assign rd_data  = rd_ok ? regs_q[rd_idx[IDX_W-1:0]] : '0;
  assign err_flag = err_q;

  // R5: once raised, the flag only drops on a clear
  a_r5_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_err) |=> err_q);
endmodule

// File: rtl/dcr_responder.sv
module dcr_responder
  import dcr_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR  = 8'h5A,
  parameter int         NREG      = 4,
  parameter bit         BYTE_MODE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dc_tag,
  input  logic        strobe,
  input  logic [15:0] addr_in,
  input  logic [15:0] data_in,
  input  logic [1:0]  par_in,
  input  logic        intr_svc,
  input  logic [7:0]  intr_info,
  output logic        ack,
  output logic        data_oe,
  output logic [15:0] data_out,
  output logic [1:0]  par_out
);
  localparam logic [NBYTE-1:0] CHK_MASK = BYTE_MODE ? 2'b01 : 2'b11;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  cmd_t cmd;
  dcr_decode #(.DEV_ADDR(DEV_ADDR)) u_dec (
    .tag(dc_tag), .strobe(strobe), .addr(addr_in), .cmd(cmd)
  );

  logic par_err;
  dcr_parity_chk #(.NB(NBYTE)) u_chk (
    .data(data_in), .par(par_in), .mask(CHK_MASK), .err(par_err)
  );

  logic        dpc, wr_seq;
  logic        st_wr_en, st_set, st_clr, err_flag;
  logic [15:0] wr_word, st_rd;

  assign dpc    = cmd.sel & ~intr_svc;
  assign wr_seq = dpc & cmd.wr;

  always_comb begin
    if (BYTE_MODE || cmd.fn == FN_BYTE) wr_word = {8'h00, data_in[7:0]};
    else                                wr_word = data_in;
  end

  assign st_wr_en = wr_seq & ~par_err & ((cmd.fn == FN_WORD) | (cmd.fn == FN_BYTE));
  assign st_clr   = wr_seq & ~par_err & (cmd.fn == FN_CTRL);
  assign st_set   = wr_seq & par_err;

  dcr_store #(.NREG(NREG), .W(BUS_W)) u_store (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(st_wr_en), .wr_idx(cmd.idx), .wr_data(wr_word),
    .set_err(st_set), .clr_err(st_clr),
    .rd_idx(cmd.idx), .rd_data(st_rd), .err_flag(err_flag)
  );

  // read word selection
  logic [15:0] rd_word;
  always_comb begin
    unique case (cmd.fn)
      FN_WORD: rd_word = st_rd;
      FN_BYTE: rd_word = {8'h00, st_rd[7:0]};
      FN_CTRL: rd_word = {15'b0, err_flag};
      default: rd_word = '0;
    endcase
  end

  // next state of the bus outputs
  logic        ack_d, oe_d;
  logic [15:0] dout_d;
  logic [1:0]  par_d;
  always_comb begin
    ack_d  = 1'b0;
    oe_d   = 1'b0;
    dout_d = '0;
    if (intr_svc) begin
      ack_d  = 1'b1;
      oe_d   = 1'b1;
      dout_d = {intr_info, DEV_ADDR};
    end else if (cmd.sel) begin
      ack_d = 1'b1;
      if (!cmd.wr) begin
        oe_d   = 1'b1;
        dout_d = rd_word;
      end
    end
  end

  for (genvar i = 0; i < NBYTE; i++) begin : g_par
    assign par_d[i] = oe_d & odd_bit(dout_d[i*8 +: 8]);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ack      <= 1'b0;
      data_oe  <= 1'b0;
      data_out <= '0;
      par_out  <= '0;
    end else begin
      ack      <= ack_d;
      data_oe  <= oe_d;
      data_out <= dout_d;
      par_out  <= par_d;
    end
  end

  // R12: an undriven bus carries zeros
  a_r12_idle_bus: assert property (@(posedge clk) disable iff (!rst_int_n)
    !data_oe |-> (data_out == 16'h0 && par_out == 2'b00));
  // R9: every driven byte has odd parity
  a_r9_odd_parity: assert property (@(posedge clk) disable iff (!rst_int_n)
    data_oe |-> ((^{data_out[15:8], par_out[1]}) && (^{data_out[7:0], par_out[0]})));
  // R3: an acknowledge always answers a request of the previous cycle
  a_r3_ack_has_cause: assert property (@(posedge clk) disable iff (!rst_int_n)
    ack |-> $past(intr_svc || (dc_tag && strobe)));
  // R2: the bus is only driven inside an acknowledged sequence
  a_r2_oe_with_ack: assert property (@(posedge clk) disable iff (!rst_int_n)
    data_oe |-> ack);
  // R11: interrupt service returns information byte and own address
  a_r11_intr_word: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ack && $past(intr_svc)) |->
      (data_oe && data_out[7:0] == DEV_ADDR && data_out[15:8] == $past(intr_info)));
endmodule

// File: tb/tb_dcr_responder.sv
`timescale 1ns/1ps
module tb_dcr_responder;
  localparam logic [7:0] DEV = 8'h3C;
  localparam int         NR  = 4;

  typedef struct packed {
    logic [31:0] due;
    logic [19:0] e0;
    logic [19:0] e1;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dc_tag = 1'b0, strobe = 1'b0, intr_svc = 1'b0;
  logic [15:0] addr_in = '0, data_in = '0;
  logic [1:0]  par_in = '0;
  logic [7:0]  intr_info = '0;

  logic ack0, oe0, ack1, oe1;
  logic [15:0] dout0, dout1;
  logic [1:0]  pout0, pout1;

  always #2 clk = ~clk;

  dcr_responder #(.DEV_ADDR(DEV), .NREG(NR), .BYTE_MODE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .dc_tag(dc_tag), .strobe(strobe), .addr_in(addr_in),
    .data_in(data_in), .par_in(par_in), .intr_svc(intr_svc), .intr_info(intr_info),
    .ack(ack0), .data_oe(oe0), .data_out(dout0), .par_out(pout0));

  dcr_responder #(.DEV_ADDR(DEV), .NREG(NR), .BYTE_MODE(1'b1)) dut_byte (
    .clk(clk), .rst_n(rst_n), .dc_tag(dc_tag), .strobe(strobe), .addr_in(addr_in),
    .data_in(data_in), .par_in(par_in), .intr_svc(intr_svc), .intr_info(intr_info),
    .ack(ack1), .data_oe(oe1), .data_out(dout1), .par_out(pout1));

  int checks = 0, fails = 0;
  logic [31:0] cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  exp_t  exp_q[$];
  string rq_q[$];

  logic [15:0] m_reg [2][NR];
  logic        m_err [2];

  function automatic logic op(input logic [7:0] b);
    return ~(^b);
  endfunction

  function automatic logic [1:0] gp(input logic [15:0] d);
    return {op(d[15:8]), op(d[7:0])};
  endfunction

  function automatic logic [19:0] drv(input logic [15:0] w);
    return {1'b1, 1'b1, w, gp(w)};
  endfunction

  task automatic chk(input string rq, input string who, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual ack=%b oe=%b data=%h par=%b expected ack=%b oe=%b data=%h par=%b",
               rq, who, got[19], got[18], got[17:2], got[1:0], exp[19], exp[18], exp[17:2], exp[1:0]);
    end
  endtask

  // monitor: pops expectations when due
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t  e;
      string r;
      e = exp_q.pop_front();
      r = rq_q.pop_front();
      chk(r, "word-dev", {ack0, oe0, dout0, pout0}, e.e0);
      chk(r, "byte-dev", {ack1, oe1, dout1, pout1}, e.e1);
    end
  end

  // reference model of one instance, built from the requirements
  task automatic model(input int m, input bit wr, input logic [1:0] fn, input logic [3:0] idx,
                       input logic [7:0] dev, input bit tag, input logic [15:0] d,
                       input logic [1:0] p, input bit irq, input logic [7:0] info,
                       output logic [19:0] r);
    bit bad;
    logic [15:0] w;
    r = '0;
    if (irq) begin
      r = drv({info, DEV});
      return;
    end
    if (!(tag && dev == DEV)) return;
    if (wr) begin
      bad = (p[0] != op(d[7:0])) || (m == 0 && p[1] != op(d[15:8]));
      if (bad) m_err[m] = 1'b1;
      else if (fn == 2'b00 && idx < NR) m_reg[m][idx] = (m == 1) ? {8'h00, d[7:0]} : d;
      else if (fn == 2'b01 && idx < NR) m_reg[m][idx] = {8'h00, d[7:0]};
      else if (fn == 2'b10) m_err[m] = 1'b0;
      r = {1'b1, 19'b0};
    end else begin
      case (fn)
        2'b00:   w = (idx < NR) ? m_reg[m][idx] : 16'h0;
        2'b01:   w = (idx < NR) ? {8'h00, m_reg[m][idx][7:0]} : 16'h0;
        2'b10:   w = {15'b0, m_err[m]};
        default: w = 16'h0;
      endcase
      r = drv(w);
    end
  endtask

  task automatic push(input string rq, input logic [19:0] e0, input logic [19:0] e1);
    exp_t e;
    e.due = cyc + 1; e.e0 = e0; e.e1 = e1;
    exp_q.push_back(e); rq_q.push_back(rq);
    e.due = cyc + 2; e.e0 = '0; e.e1 = '0;
    exp_q.push_back(e); rq_q.push_back("R3 R12 idle");
  endtask

  task automatic seq(input bit irq, input logic [7:0] info, input bit wr, input logic [1:0] fn,
                     input logic [3:0] idx, input logic [7:0] dev, input bit cs, input bit tag,
                     input logic [15:0] d, input logic [1:0] p, input string rq);
    logic [19:0] e0, e1;
    @(negedge clk);
    intr_svc = irq; intr_info = info;
    dc_tag = tag; strobe = 1'b1;
    addr_in = {cs, wr, fn, idx, dev};
    data_in = d; par_in = p;
    model(0, wr, fn, idx, dev, tag, d, p, irq, info, e0);
    model(1, wr, fn, idx, dev, tag, d, p, irq, info, e1);
    push(rq, e0, e1);
    @(negedge clk);
    intr_svc = 1'b0; intr_info = '0; dc_tag = 1'b0; strobe = 1'b0;
    addr_in = '0; data_in = '0; par_in = '0;
  endtask

  task automatic wr_op(input logic [1:0] fn, input logic [3:0] idx, input logic [15:0] d,
                       input logic [1:0] p, input string rq);
    seq(1'b0, 8'h00, 1'b1, fn, idx, DEV, 1'b0, 1'b1, d, p, rq);
  endtask

  task automatic rd_op(input logic [1:0] fn, input logic [3:0] idx, input string rq);
    seq(1'b0, 8'h00, 1'b0, fn, idx, DEV, 1'b0, 1'b1, 16'h0, 2'b00, rq);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      m_err[m] = 1'b0;
      for (int i = 0; i < NR; i++) m_reg[m][i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 reset", "word-dev", {ack0, oe0, dout0, pout0}, 20'h0);
    chk("R1 reset", "byte-dev", {ack1, oe1, dout1, pout1}, 20'h0);
    rd_op(2'b10, 4'd0, "R1 R10 status after reset");
    rd_op(2'b00, 4'd1, "R1 register clear after reset");

    // R4 R6 R8 R9: word write and readback
    wr_op(2'b00, 4'd0, 16'h1234, gp(16'h1234), "R4 word write ack");
    rd_op(2'b00, 4'd0, "R6 R8 R9 word read");
    // R2: channel-select bit has no effect
    seq(1'b0, 8'h00, 1'b1, 2'b00, 4'd1, DEV, 1'b1, 1'b1, 16'hABCD, gp(16'hABCD), "R2 chan-select write");
    rd_op(2'b00, 4'd1, "R2 R8 readback reg1");
    // R2: other device address and missing tag
    seq(1'b0, 8'h00, 1'b1, 2'b00, 4'd1, 8'h3D, 1'b0, 1'b1, 16'h5555, gp(16'h5555), "R2 foreign address");
    seq(1'b0, 8'h00, 1'b0, 2'b00, 4'd1, DEV, 1'b0, 1'b0, 16'h0, 2'b00, "R2 tag low");
    rd_op(2'b00, 4'd1, "R2 reg1 untouched");
    // R7: byte write
    wr_op(2'b01, 4'd2, 16'h9977, gp(16'h9977), "R7 byte write");
    rd_op(2'b00, 4'd2, "R7 word read of byte");
    rd_op(2'b01, 4'd1, "R8 byte read");
    // R5 R6: bad high-byte parity
    wr_op(2'b00, 4'd0, 16'hF0F1, gp(16'hF0F1) ^ 2'b10, "R5 R6 bad high parity");
    rd_op(2'b00, 4'd0, "R5 R6 reg0 after bad high");
    rd_op(2'b10, 4'd0, "R5 R6 R10 status after bad high");
    // R5: bad low parity, both drop
    wr_op(2'b00, 4'd3, 16'h0102, gp(16'h0102) ^ 2'b01, "R5 bad low parity");
    rd_op(2'b00, 4'd3, "R5 reg3 discarded");
    wr_op(2'b00, 4'd3, 16'h0304, gp(16'h0304), "R5 good write after error");
    rd_op(2'b10, 4'd0, "R5 flag sticky");
    rd_op(2'b00, 4'd3, "R5 reg3 good data");
    // R10: clear
    wr_op(2'b10, 4'd0, 16'h0000, gp(16'h0000), "R10 control clear");
    rd_op(2'b10, 4'd0, "R10 status cleared");
    // R4: out-of-range index and reserved function
    wr_op(2'b00, 4'd5, 16'h7777, gp(16'h7777), "R4 out-of-range write");
    rd_op(2'b00, 4'd5, "R4 out-of-range read");
    wr_op(2'b11, 4'd0, 16'h4444, gp(16'h4444), "R4 reserved write");
    rd_op(2'b11, 4'd0, "R4 reserved read");
    rd_op(2'b00, 4'd0, "R4 reg0 after reserved");
    // R11: interrupt service, alone and with a competing write
    seq(1'b1, 8'hA5, 1'b0, 2'b00, 4'd0, 8'h00, 1'b0, 1'b0, 16'h0, 2'b00, "R11 interrupt word");
    seq(1'b1, 8'h81, 1'b1, 2'b00, 4'd1, DEV, 1'b0, 1'b1, 16'hDEAD, gp(16'hDEAD), "R11 interrupt priority");
    rd_op(2'b00, 4'd1, "R11 reg1 unchanged");
    rd_op(2'b10, 4'd0, "R11 status unchanged");

    repeat (4) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog all requirements: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule